// File: doc/BRIEF.md
# Area-Lean 3x3 Integer Matrix Product Engine

This block forms the product C = A x B of two square matrices of small unsigned integers. It uses one multiplier per inner-product term and one adder fewer than that. Completion time is traded for area: the result comes out one element per clock, so an N x N product takes N*N cycles of issue.

Software or a neighbouring block first fills both operand matrices through a single-element write port. A one-cycle start pulse then launches the computation. Each result element leaves the block on a registered output with a valid strobe and its row and column index, in row-major order. A one-cycle done pulse follows the last element.

Internally, lane k holds column k of A and row k of B. Lane k keeps each A element for N cycles while the B row cycles around. The N lane products are registered and then summed into one output element.

Top module: `mmseq_top`

## Requirements
- R1: Reset (synchronous, active high) clears busy, out_valid and done to 0.
- R2: While idle, a write with wr_en high stores wr_data into A when wr_mat is 0, or into B when wr_mat is 1. The element stored is the one at row wr_row, column wr_col, with indices starting at 0. A later write to the same place replaces the value.
- R3: A write presented while busy is high is ignored. Neither the running product nor later products see it.
- R4: A start pulse sampled while idle raises busy at that clock edge. busy stays high until the edge at which done rises.
- R5: Take the accepted start edge as edge 0. out_valid is then high for exactly N*N consecutive cycles, starting after edge 3.
- R6: Results appear in row-major order, with out_row and out_col giving the element's position: (0,0), (0,1), ... up to (N-1,N-1).
- R7: out_data equals the exact sum over k of A[row][k]*B[k][col]. It is 2*W+ceil(log2 N) bits wide (18 bits for W=8, N=3), so no result can overflow, all-maximum operands included.
- R8: done is high for exactly one cycle, the cycle right after the last valid element. busy falls at that same edge.
- R9: A start pulse presented while busy is high is ignored. The run keeps exactly N*N outputs and one done pulse, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_mat | input | 1 | Target matrix: 0 = A, 1 = B |
| wr_row | input | IW (2) | Row of the element written |
| wr_col | input | IW (2) | Column of the element written |
| wr_data | input | W (8) | Element value |
| start | input | 1 | One-cycle launch pulse |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | out_data/out_row/out_col carry a result |
| out_row | output | IW (2) | Row index of the result |
| out_col | output | IW (2) | Column index of the result |
| out_data | output | SW (18) | Result element |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with N=3 and W=8. This configuration is small enough to check every output element of every run against a product computed in the bench, on every cycle of a fixed timing window. Runs cover identity, zero and all-255 matrices, the last of which reaches the widest possible sum. They also cover a sweep of pseudo-random matrices, so each lane and every row-column pairing carries varied data. Disturbed runs inject a start pulse and an operand write in mid-run, and a rerun without reloading shows that neither left a trace.

// File: rtl/mmseq_pkg.sv
package mmseq_pkg;

  // index width for an N-entry dimension (at least one bit)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // result width that cannot overflow: 2W product plus growth of an N-term sum
  function automatic int sum_bits(input int w, input int n);
    return 2 * w + ((n > 1) ? $clog2(n) : 0);
  endfunction

endpackage

// File: rtl/mmseq_lane.sv
// One multiplier lane: holds column k of A and row k of B, reads both
// synchronously, and registers their product.
module mmseq_lane #(
  parameter int W  = 8,
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            we_a,
  input  logic            we_b,
  input  logic [IW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [IW-1:0]   rd_a,
  input  logic [IW-1:0]   rd_b,
  output logic [2*W-1:0]  prod
);

  logic [W-1:0] a_mem [N];
  logic [W-1:0] b_mem [N];
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (we_a && int'(wr_addr) < N) a_mem[wr_addr] <= wr_data;
    if (we_b && int'(wr_addr) < N) b_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    a_q  <= a_mem[rd_a];
    b_q  <= b_mem[rd_b];
    prod <= a_q * b_q;
  end

endmodule

// File: rtl/mmseq_sum.sv
// N-1 adder reduction of the lane products, registered at the output.
module mmseq_sum #(
  parameter int N  = 3,
  parameter int PW = 16,
  parameter int SW = 18
) (
  input  logic            clk,
  input  logic [N*PW-1:0] prods,
  output logic [SW-1:0]   sum
);

  logic [SW-1:0] acc;

  always_comb begin
    acc = SW'(prods[PW-1:0]);
    for (int k = 1; k < N; k++) begin
      acc = acc + SW'(prods[k*PW +: PW]);
    end
  end

  always_ff @(posedge clk) sum <= acc;

endmodule

// File: rtl/mmseq_ctrl.sv
// Run control: issue counters, valid/index pipeline aligned with the
// datapath, busy and done.
module mmseq_ctrl #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] iss_row,
  output logic [IW-1:0] iss_col,
  output logic          out_valid,
  output logic [IW-1:0] out_row,
  output logic [IW-1:0] out_col,
  output logic          done
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);
  localparam int DEPTH = 3;   // memory read, product register, sum register

  logic                issuing;
  logic [DEPTH-1:0]    v_pipe;
  logic [IW-1:0]       r_pipe [DEPTH];
  logic [IW-1:0]       c_pipe [DEPTH];
  logic                last_out;

  assign last_out  = v_pipe[DEPTH-1] && r_pipe[DEPTH-1] == LAST && c_pipe[DEPTH-1] == LAST;
  assign out_valid = v_pipe[DEPTH-1];
  assign out_row   = r_pipe[DEPTH-1];
  assign out_col   = c_pipe[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      iss_row <= '0;
      iss_col <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_out;
      if (!busy && start) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        iss_row <= '0;
        iss_col <= '0;
      end else begin
        if (issuing) begin
          if (iss_col == LAST) begin
            iss_col <= '0;
            if (iss_row == LAST) issuing <= 1'b0;
            else                 iss_row <= iss_row + 1'b1;
          end else begin
            iss_col <= iss_col + 1'b1;
          end
        end
        if (last_out) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_pipe <= '0;
    else     v_pipe <= {v_pipe[DEPTH-2:0], issuing};
    r_pipe[0] <= iss_row;
    c_pipe[0] <= iss_col;
    for (int s = 1; s < DEPTH; s++) begin
      r_pipe[s] <= r_pipe[s-1];
      c_pipe[s] <= c_pipe[s-1];
    end
  end

  // checker state: results delivered in the current run
  int unsigned n_out;
  always_ff @(posedge clk) begin
    if (rst || done)    n_out <= 0;
    else if (out_valid) n_out <= n_out + 1;
  end

  p_valid_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  p_burst_len_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> n_out < N * N);

  p_row_major_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |->
      ((out_col == '0) ? ($past(out_col) == LAST && out_row == $past(out_row) + 1'b1)
                       : (out_col == $past(out_col) + 1'b1 && out_row == $past(out_row))));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_ends_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

// File: rtl/mmseq_top.sv
module mmseq_top #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int IW = mmseq_pkg::idx_bits(N),
  localparam int SW = mmseq_pkg::sum_bits(W, N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_mat,
  input  logic [IW-1:0] wr_row,
  input  logic [IW-1:0] wr_col,
  input  logic [W-1:0]  wr_data,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  output logic [IW-1:0] out_row,
  output logic [IW-1:0] out_col,
  output logic [SW-1:0] out_data,
  output logic          done
);

  localparam int PW = 2 * W;

  logic [IW-1:0]   iss_row, iss_col;
  logic [N*PW-1:0] prods;
  logic            wr_ok;
  logic [IW-1:0]   wr_addr;

  assign wr_ok   = wr_en && !busy;
  assign wr_addr = wr_mat ? wr_col : wr_row;   // A: row within column k; B: column within row k

  mmseq_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .iss_row(iss_row), .iss_col(iss_col),
    .out_valid(out_valid), .out_row(out_row), .out_col(out_col), .done(done)
  );

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic we_a, we_b;
    assign we_a = wr_ok && !wr_mat && wr_col == IW'(k);
    assign we_b = wr_ok &&  wr_mat && wr_row == IW'(k);

    mmseq_lane #(.W(W), .N(N), .IW(IW)) u_lane (
      .clk(clk), .we_a(we_a), .we_b(we_b), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_a(iss_row), .rd_b(iss_col), .prod(prods[k*PW +: PW])
    );
  end

  mmseq_sum #(.N(N), .PW(PW), .SW(SW)) u_sum (
    .clk(clk), .prods(prods), .sum(out_data)
  );

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

endmodule

// File: tb/mmseq_top_test.sv
module mmseq_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_mat = 1'b0;
  logic [1:0] wr_row = '0, wr_col = '0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       busy, out_valid, done;
  logic [1:0] out_row, out_col;
  logic [17:0] out_data;

  int ma [3][3];
  int mb [3][3];
  int errors = 0;
  int checks = 0;
  int seed = 12345;

  always #4 clk = ~clk;

  mmseq_top #(.N(3), .W(8)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mat(wr_mat), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .start(start), .busy(busy),
    .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
    .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int prod_elem(input int i, input int j);
    int s = 0;
    for (int k = 0; k < 3; k++) s += ma[i][k] * mb[k][j];
    return s;
  endfunction

  function automatic int next_rand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 16) & 255;
  endfunction

  task automatic wr(input bit m, input int r, input int c, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_mat = m; wr_row = 2'(r); wr_col = 2'(c); wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (m) mb[r][c] = v; else ma[r][c] = v;
  endtask

  task automatic load_all();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        wr(1'b0, r, c, ma[r][c]);
        wr(1'b1, r, c, mb[r][c]);
      end
  endtask

  // disturb=1: mid-run operand write (t=4) and start pulse (t=5..6)
  task automatic run(input bit disturb);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 15; t++) begin
      bit exp_v = (t >= 3 && t <= 11);
      chk(busy == (t <= 11), "R4 busy", busy, t <= 11);
      chk(out_valid == exp_v, "R5 out_valid", out_valid, exp_v);
      chk(done == (t == 12), "R8 done", done, t == 12);
      if (disturb) chk(done == (t == 12), "R9 single done", done, t == 12);
      if (exp_v && out_valid) begin
        int i = (t - 3) / 3;
        int j = (t - 3) % 3;
        chk(out_row == 2'(i) && out_col == 2'(j), "R6 index",
            {out_row, out_col}, (i << 2) | j);
        chk(out_data == 18'(prod_elem(i, j)), disturb ? "R3 R7 data" : "R7 data",
            out_data, prod_elem(i, j));
      end
      if (disturb) begin
        if (t == 4) begin
          wr_en = 1'b1; wr_mat = 1'b0; wr_row = 2'd0; wr_col = 2'd0;
          wr_data = 8'(ma[0][0] ^ 8'h5A);
        end
        if (t == 5) begin wr_en = 1'b0; start = 1'b1; end
        if (t == 6) start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);

    // identity A, distinct B
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        ma[r][c] = (r == c) ? 1 : 0;
        mb[r][c] = 10 * r + c + 1;
      end
    load_all(); run(1'b0);

    // all maximum: widest sum
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin ma[r][c] = 255; mb[r][c] = 255; end
    load_all(); run(1'b0);

    // zeros
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin ma[r][c] = 0; mb[r][c] = 0; end
    load_all(); run(1'b0);

    // pseudo-random sweep
    for (int n = 0; n < 16; n++) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) begin ma[r][c] = next_rand(); mb[r][c] = next_rand(); end
      load_all(); run(1'b0);
    end

    // mid-run write and start are ignored (R3, R9); rerun proves storage untouched
    run(1'b1);
    run(1'b0);

    // R2: single-element overwrite in each matrix while idle
    wr(1'b0, 2, 1, 200);
    wr(1'b1, 1, 2, 77);
    run(1'b0);
    wr(1'b1, 0, 0, 3);
    run(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule